// File: doc/BRIEF.md
# Memory-Mapped Serial Receive FIFO Port

This block is the register front end of a simple serial port. A host reaches it over a small memory-mapped bus with a valid/ready handshake. Incoming bytes from a byte-wide receive stream are stored, zero-extended, in a circular FIFO of 32-bit words, and the host drains them by reading the data register. A write to the data register sends its low byte out on a byte transmit stream in the following cycle. The baud timing and line framing are handled elsewhere.

For bulk transfers, the block holds the address and count registers for two external DMA engines and drives them as ports. While a receive DMA count is outstanding, every incoming byte bypasses the FIFO and goes to the receive DMA port. Each such byte decrements the outstanding count and advances the DMA address. A single level interrupt, registered one cycle behind its sources, combines three enable bits with the FIFO occupancy and the receive DMA state.

Top module: `serial_rx_port`

## Requirements
- R1: Only `req_addr[11:2]` selects a register. Index 0 is identity, 1 is data, 2 is FIFO occupancy, 3 is interrupt enable, 4 is TX DMA address, 5 is TX DMA count, 6 is RX DMA address, 7 is RX DMA remaining count and 8 is FIFO depth. Reads of any other index return 0. Writes to indices 0, 2, 8 or any undefined index change nothing. The interrupt enable reads back as its three stored bits.
- R2: Index 0 reads the parameter `ID_VALUE`, which defaults to 0x5E710001. Index 8 reads the parameter `DEPTH`, which defaults to 16.
- R3: A data read with a non-empty FIFO returns the oldest entry and removes it. A data read with an empty FIFO returns 0xFFFFFFFF and leaves the occupancy at 0.
- R4: Received bytes come out of the FIFO in arrival order, zero-extended to 32 bits. Storage is a ring of `DEPTH` words that wraps from the last slot to slot 0.
- R5: While no receive DMA is outstanding, `rx_ready` is low exactly when the FIFO holds `DEPTH` entries. The occupancy never exceeds `DEPTH`.
- R6: A byte accepted in the same cycle as a data-read pop leaves the occupancy unchanged.
- R7: A write to index 1 raises `tx_valid` for one cycle, starting the cycle after acceptance, with `tx_byte` equal to the low 8 bits of the written word.
- R8: Interrupt enable bit 0 gates "FIFO non-empty", bit 1 asserts unconditionally, and bit 2 gates "RX DMA remaining count is zero". `irq` is the OR of the three terms and is registered, so it follows its sources one cycle later.
- R9: A write to index 7 loads the RX DMA remaining count. While that count is nonzero, `rx_ready` is high and each accepted byte appears on `dma_rx_valid`/`dma_rx_byte` in that cycle. Each such byte decrements the count and increments `dma_rx_addr`, and the FIFO is untouched.
- R10: A write to index 6 loads `dma_rx_addr` and cancels any outstanding receive DMA by clearing the remaining count to 0.
- R11: A nonzero write to index 5 pulses `dma_tx_go` for one cycle, the cycle after acceptance, with `dma_tx_len` holding the value. A zero write gives no pulse. Index 5 always reads 0, and index 4 reads back the value last written.
- R12: `req_ready` is always high. Every accepted request gives `rsp_valid` for one cycle in the next cycle, with the read value on `rsp_rdata`, or 0 for a write. After reset `rsp_valid`, `tx_valid`, `dma_tx_go` and `irq` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Bus request valid |
| req_ready | output | 1 | Bus request ready (always high) |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | 32 | Byte address; bits 11:2 select the register |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response valid, one cycle after acceptance |
| rsp_rdata | output | 32 | Read data |
| rx_valid | input | 1 | Received byte valid |
| rx_byte | input | 8 | Received byte |
| rx_ready | output | 1 | Receiver may present a byte |
| tx_valid | output | 1 | Transmit byte strobe |
| tx_byte | output | 8 | Transmit byte |
| irq | output | 1 | Level interrupt |
| dma_tx_addr | output | 32 | TX DMA start address |
| dma_tx_go | output | 1 | TX DMA start pulse |
| dma_tx_len | output | 32 | TX DMA byte count |
| dma_rx_addr | output | 32 | Current RX DMA address |
| dma_rx_remaining | output | 32 | RX DMA bytes still expected |
| dma_rx_valid | output | 1 | Received byte routed to RX DMA |
| dma_rx_byte | output | 8 | Byte routed to RX DMA |

## Verification
A wrong ring pointer or occupancy shows up at the data register. It appears as bytes returned out of arrival order, or as a premature all-ones read, on the first read after the wrap point, or as `rx_ready` dropping at the wrong fill level. A bad receive-routing decision is visible in the same cycle as the byte: it shows as a missing `dma_rx_valid` or a FIFO occupancy that grows while a DMA is outstanding. A stale interrupt term shows at `irq` exactly one cycle after the enable, occupancy or remaining count changes, so the bench samples it one cycle after each change.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;
  localparam int unsigned IDX_W = 10;

  localparam logic [IDX_W-1:0] IDX_IDENT  = 10'd0;
  localparam logic [IDX_W-1:0] IDX_DATA   = 10'd1;
  localparam logic [IDX_W-1:0] IDX_LEVEL  = 10'd2;
  localparam logic [IDX_W-1:0] IDX_IEN    = 10'd3;
  localparam logic [IDX_W-1:0] IDX_TXADDR = 10'd4;
  localparam logic [IDX_W-1:0] IDX_TXLEN  = 10'd5;
  localparam logic [IDX_W-1:0] IDX_RXADDR = 10'd6;
  localparam logic [IDX_W-1:0] IDX_RXLEN  = 10'd7;
  localparam logic [IDX_W-1:0] IDX_DEPTH  = 10'd8;

  localparam int unsigned IEN_W = 3;
  typedef struct packed {
    logic rx_done;   // bit 2
    logic tx_dma;    // bit 1
    logic fifo_data; // bit 0
  } ien_t;
endpackage

// File: rtl/srx_ring_fifo.sv
module srx_ring_fifo #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned W     = 32,
  localparam int unsigned PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  push_data,
  input  logic          pop,
  output logic [W-1:0]  head,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] rd_pos_q, rd_pos_d;
  logic [CW-1:0] count_q, count_d;
  logic [PW:0]   slot_sum;
  logic [PW-1:0] wr_slot;

  // push slot = (read position + occupancy) modulo depth
  always_comb begin
    slot_sum = (PW+1)'(rd_pos_q) + (PW+1)'(count_q);
    if (slot_sum >= (PW+1)'(DEPTH)) slot_sum = slot_sum - (PW+1)'(DEPTH);
    wr_slot = slot_sum[PW-1:0];
  end

  always_comb begin
    rd_pos_d = rd_pos_q;
    count_d  = count_q;
    if (pop) begin
      rd_pos_d = (rd_pos_q == PW'(DEPTH - 1)) ? '0 : rd_pos_q + PW'(1);
    end
    unique case ({push, pop})
      2'b10:   count_d = count_q + CW'(1);
      2'b01:   count_d = count_q - CW'(1);
      default: count_d = count_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_pos_q <= '0;
      count_q  <= '0;
    end else begin
      rd_pos_q <= rd_pos_d;
      count_q  <= count_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_slot] <= push_data;
  end

  assign head  = mem[rd_pos_q];
  assign count = count_q;
  assign full  = (count_q == CW'(DEPTH));
  assign empty = (count_q == '0);
endmodule

// File: rtl/srx_rx_route.sv
module srx_rx_route #(
  parameter int unsigned AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          addr_we,
  input  logic          len_we,
  input  logic [AW-1:0] wdata,
  input  logic          rx_valid,
  input  logic          fifo_full,
  output logic          rx_ready,
  output logic          to_fifo,
  output logic          to_dma,
  output logic [AW-1:0] rem,
  output logic [AW-1:0] addr
);
  logic [AW-1:0] rem_q, rem_d, addr_q, addr_d;
  logic          rem_zero;

  assign rem_zero = (rem_q == '0);
  assign rx_ready = !rem_zero || !fifo_full;
  assign to_fifo  = rx_valid && rem_zero && !fifo_full;
  assign to_dma   = rx_valid && !rem_zero;

  always_comb begin
    rem_d  = rem_q;
    addr_d = addr_q;
    if (to_dma) begin
      rem_d  = rem_q - AW'(1);
      addr_d = addr_q + AW'(1);
    end
    if (len_we) rem_d = wdata;
    if (addr_we) begin
      rem_d  = '0;
      addr_d = wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      addr_q <= '0;
    end else begin
      rem_q  <= rem_d;
      addr_q <= addr_d;
    end
  end

  assign rem  = rem_q;
  assign addr = addr_q;
endmodule

// File: rtl/srx_irq_gen.sv
module srx_irq_gen
  import serial_rx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  ien_t ien,
  input  logic fifo_nonempty,
  input  logic rx_rem_zero,
  output logic irq
);
  logic irq_q, irq_d;

  always_comb begin
    irq_d = (ien.fifo_data && fifo_nonempty)
         || ien.tx_dma
         || (ien.rx_done && rx_rem_zero);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign irq = irq_q;
endmodule

// File: rtl/serial_rx_port.sv
module serial_rx_port
  import serial_rx_pkg::*;
#(
  parameter int unsigned DEPTH    = 16,
  parameter logic [31:0] ID_VALUE = 32'h5E71_0001,
  localparam int unsigned DW      = 32,
  localparam int unsigned CW      = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [DW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  input  logic          rx_valid,
  input  logic [7:0]    rx_byte,
  output logic          rx_ready,
  output logic          tx_valid,
  output logic [7:0]    tx_byte,
  output logic          irq,
  output logic [DW-1:0] dma_tx_addr,
  output logic          dma_tx_go,
  output logic [DW-1:0] dma_tx_len,
  output logic [DW-1:0] dma_rx_addr,
  output logic [DW-1:0] dma_rx_remaining,
  output logic          dma_rx_valid,
  output logic [7:0]    dma_rx_byte
);
  // reset: asserted asynchronously, released after two clock edges
  logic [1:0] rst_pipe;
  logic       rst_q_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_q_n = rst_pipe[1];

  // decode
  logic             acc;
  logic [IDX_W-1:0] idx;
  logic             wr_ien, wr_txaddr, wr_txlen, wr_rxaddr, wr_rxlen;
  logic             data_wr_acc, data_rd_acc;
  logic             unused_addr_bits;

  assign req_ready        = 1'b1;
  assign acc              = req_valid;
  assign idx              = req_addr[11:2];
  assign unused_addr_bits = ^{req_addr[DW-1:12], req_addr[1:0]};
  assign wr_ien           = acc && req_write && (idx == IDX_IEN);
  assign wr_txaddr        = acc && req_write && (idx == IDX_TXADDR);
  assign wr_txlen         = acc && req_write && (idx == IDX_TXLEN);
  assign wr_rxaddr        = acc && req_write && (idx == IDX_RXADDR);
  assign wr_rxlen         = acc && req_write && (idx == IDX_RXLEN);
  assign data_wr_acc      = acc && req_write && (idx == IDX_DATA);
  assign data_rd_acc      = acc && !req_write && (idx == IDX_DATA);

  // FIFO and receive routing
  logic          fifo_push, fifo_pop, fifo_full, fifo_empty;
  logic [DW-1:0] fifo_head;
  logic [CW-1:0] fifo_cnt;
  logic [DW-1:0] rx_rem, rx_addr;

  assign fifo_pop = data_rd_acc && !fifo_empty;

  srx_ring_fifo #(.DEPTH(DEPTH), .W(DW)) u_fifo (
    .clk(clk), .rst_n(rst_q_n),
    .push(fifo_push), .push_data({24'h0, rx_byte}), .pop(fifo_pop),
    .head(fifo_head), .count(fifo_cnt), .full(fifo_full), .empty(fifo_empty)
  );

  srx_rx_route #(.AW(DW)) u_route (
    .clk(clk), .rst_n(rst_q_n),
    .addr_we(wr_rxaddr), .len_we(wr_rxlen), .wdata(req_wdata),
    .rx_valid(rx_valid), .fifo_full(fifo_full), .rx_ready(rx_ready),
    .to_fifo(fifo_push), .to_dma(dma_rx_valid),
    .rem(rx_rem), .addr(rx_addr)
  );

  assign dma_rx_byte      = rx_byte;
  assign dma_rx_addr      = rx_addr;
  assign dma_rx_remaining = rx_rem;

  // local registers
  ien_t          ien_q, ien_d;
  logic [DW-1:0] txaddr_q, txaddr_d, txlen_q, txlen_d;
  logic          go_q, go_d, txv_q, txv_d, rspv_q, rspv_d;
  logic [7:0]    txb_q, txb_d;
  logic [DW-1:0] rdat_q, rdat_d, rd_mux;

  always_comb begin
    unique case (idx)
      IDX_IDENT:  rd_mux = ID_VALUE;
      IDX_DATA:   rd_mux = fifo_empty ? '1 : fifo_head;
      IDX_LEVEL:  rd_mux = DW'(fifo_cnt);
      IDX_IEN:    rd_mux = DW'(ien_q);
      IDX_TXADDR: rd_mux = txaddr_q;
      IDX_TXLEN:  rd_mux = '0;
      IDX_RXADDR: rd_mux = rx_addr;
      IDX_RXLEN:  rd_mux = rx_rem;
      IDX_DEPTH:  rd_mux = DW'(DEPTH);
      default:    rd_mux = '0;
    endcase
  end

  always_comb begin
    ien_d    = wr_ien ? ien_t'(req_wdata[IEN_W-1:0]) : ien_q;
    txaddr_d = wr_txaddr ? req_wdata : txaddr_q;
    txlen_d  = wr_txlen ? req_wdata : txlen_q;
    go_d     = wr_txlen && (req_wdata != '0);
    txv_d    = data_wr_acc;
    txb_d    = data_wr_acc ? req_wdata[7:0] : txb_q;
    rspv_d   = acc;
    rdat_d   = (acc && !req_write) ? rd_mux : '0;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      ien_q    <= '0;
      txaddr_q <= '0;
      txlen_q  <= '0;
      go_q     <= 1'b0;
      txv_q    <= 1'b0;
      txb_q    <= '0;
      rspv_q   <= 1'b0;
      rdat_q   <= '0;
    end else begin
      ien_q    <= ien_d;
      txaddr_q <= txaddr_d;
      txlen_q  <= txlen_d;
      go_q     <= go_d;
      txv_q    <= txv_d;
      txb_q    <= txb_d;
      rspv_q   <= rspv_d;
      rdat_q   <= rdat_d;
    end
  end

  srx_irq_gen u_irq (
    .clk(clk), .rst_n(rst_q_n), .ien(ien_q),
    .fifo_nonempty(!fifo_empty), .rx_rem_zero(rx_rem == '0), .irq(irq)
  );

  assign rsp_valid   = rspv_q;
  assign rsp_rdata   = rdat_q;
  assign tx_valid    = txv_q;
  assign tx_byte     = txb_q;
  assign dma_tx_addr = txaddr_q;
  assign dma_tx_go   = go_q;
  assign dma_tx_len  = txlen_q;
endmodule

// File: rtl/serial_rx_port_chk.sv
module serial_rx_port_chk #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic [CW-1:0] fifo_cnt,
  input logic          fifo_full,
  input logic          fifo_push,
  input logic          fifo_pop,
  input logic [31:0]   rx_rem,
  input logic          rx_ready,
  input logic          rx_valid,
  input logic [2:0]    ien,
  input logic          irq,
  input logic          data_rd_acc,
  input logic          data_wr_acc,
  input logic          tx_valid,
  input logic          dma_rx_valid
);
  a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_cnt <= CW'(DEPTH));

  a_r5_stall_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_full && rx_rem == 32'd0) |-> !rx_ready);

  a_r6_push_pop_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_push && fifo_pop) |=> $stable(fifo_cnt));

  a_r3_empty_read_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd_acc && fifo_cnt == '0 && !fifo_push) |=> (fifo_cnt == '0));

  a_r8_tx_enable_forces: assert property (@(posedge clk) disable iff (!rst_n)
    ien[1] |=> irq);

  a_r9_dma_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_rem != 32'd0) |-> (dma_rx_valid && !fifo_push && rx_ready));

  a_r7_tx_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> $past(data_wr_acc));
endmodule

bind serial_rx_port serial_rx_port_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_q_n), .fifo_cnt(fifo_cnt), .fifo_full(fifo_full),
  .fifo_push(fifo_push), .fifo_pop(fifo_pop), .rx_rem(rx_rem),
  .rx_ready(rx_ready), .rx_valid(rx_valid), .ien(ien_q), .irq(irq),
  .data_rd_acc(data_rd_acc), .data_wr_acc(data_wr_acc),
  .tx_valid(tx_valid), .dma_rx_valid(dma_rx_valid)
);

// File: tb/serial_rx_port_tb.sv
`timescale 1ns/1ps
module serial_rx_port_tb;
  localparam logic [31:0] ID_EXP = 32'h5E71_0001;
  localparam int NV = 16;
  // {write, addr, wdata, expected response data}
  localparam logic [96:0] VEC [NV] = '{
    {1'b0, 32'h0000_0000, 32'h0,         ID_EXP},         // R2 identity
    {1'b1, 32'h0000_0000, 32'h0000_FFFF, 32'h0},          // R1 write to read-only
    {1'b0, 32'h0000_0000, 32'h0,         ID_EXP},         // R1 identity kept
    {1'b0, 32'h0000_0020, 32'h0,         32'd16},         // R2 depth
    {1'b0, 32'h0000_0008, 32'h0,         32'd0},          // R1 occupancy
    {1'b0, 32'h0000_0004, 32'h0,         32'hFFFF_FFFF},  // R3 empty read
    {1'b0, 32'h0000_0008, 32'h0,         32'd0},          // R3 still empty
    {1'b1, 32'h0000_0010, 32'h0000_1000, 32'h0},          // R11 tx addr
    {1'b0, 32'hABC0_1010, 32'h0,         32'h0000_1000},  // R1 upper bits ignored
    {1'b0, 32'h0000_0014, 32'h0,         32'h0},          // R11 tx count reads 0
    {1'b1, 32'h0000_0018, 32'h0000_2000, 32'h0},          // R10 rx addr
    {1'b0, 32'h0000_0018, 32'h0,         32'h0000_2000},  // R10 readback
    {1'b0, 32'h0000_0024, 32'h0,         32'h0},          // R1 undefined index
    {1'b1, 32'h0000_0008, 32'd5,         32'h0},          // R1 write occupancy
    {1'b0, 32'h0000_0008, 32'h0,         32'd0},          // R1 unchanged
    {1'b0, 32'h0000_0FFC, 32'h0,         32'h0}           // R1 undefined top index
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_ready;
  logic [31:0] req_addr = '0, req_wdata = '0;
  logic rsp_valid; logic [31:0] rsp_rdata;
  logic rx_valid = 1'b0; logic [7:0] rx_byte = '0; logic rx_ready;
  logic tx_valid; logic [7:0] tx_byte; logic irq;
  logic [31:0] dma_tx_addr, dma_tx_len, dma_rx_addr, dma_rx_remaining;
  logic dma_tx_go, dma_rx_valid; logic [7:0] dma_rx_byte;

  serial_rx_port u_dut (.*);

  always #4 clk = ~clk; // 125 MHz

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;
  logic [31:0] rd; logic rv, tv, go; logic [7:0] tb; logic [31:0] gl;
  logic dv, rr; logic [7:0] db;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus(input logic w, input logic [31:0] a, input logic [31:0] d);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0;
    rd = rsp_rdata; rv = rsp_valid; tv = tx_valid; tb = tx_byte;
    go = dma_tx_go; gl = dma_tx_len;
  endtask

  task automatic send(input logic [7:0] b);
    rx_valid = 1'b1; rx_byte = b; #1;
    dv = dma_rx_valid; db = dma_rx_byte; rr = rx_ready;
    @(posedge clk); @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual %h expected %h", 32'd1, 32'd0);
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R12 reset state
    chk("R12 rsp_valid after reset", {31'h0, rsp_valid}, 32'd0);
    chk("R12 irq after reset", {31'h0, irq}, 32'd0);
    chk("R12 tx_valid after reset", {31'h0, tx_valid}, 32'd0);
    chk("R12 req_ready", {31'h0, req_ready}, 32'd1);
    chk("R5 rx_ready after reset", {31'h0, rx_ready}, 32'd1);

    for (int i = 0; i < NV; i++) begin
      bus(VEC[i][96], VEC[i][95:64], VEC[i][63:32]);
      chk($sformatf("R12 rsp_valid vector %0d", i), {31'h0, rv}, 32'd1);
      chk($sformatf("R1 table vector %0d data", i), rd, VEC[i][31:0]);
    end

    // R4 order of arrival
    send(8'hA1); send(8'hB2); send(8'hC3);
    bus(1'b0, 32'h8, 0); chk("R4 occupancy 3", rd, 32'd3);
    bus(1'b0, 32'h4, 0); chk("R4 first byte", rd, 32'h0000_00A1);
    bus(1'b0, 32'h4, 0); chk("R4 second byte", rd, 32'h0000_00B2);

    // R8 FIFO term
    bus(1'b1, 32'hC, 32'h1); tick();
    chk("R8 irq with data and bit 0", {31'h0, irq}, 32'd1);
    bus(1'b0, 32'hC, 0); chk("R1 enable readback", rd, 32'h1);
    bus(1'b0, 32'h4, 0); chk("R4 third byte", rd, 32'h0000_00C3);
    tick();
    chk("R8 irq drops when empty", {31'h0, irq}, 32'd0);

    // R5 fill to depth, R4 wrap (read position starts at 3)
    for (int i = 0; i < 16; i++) send(8'h10 + 8'(i));
    chk("R5 rx_ready low when full", {31'h0, rx_ready}, 32'd0);
    bus(1'b0, 32'h8, 0); chk("R5 occupancy at depth", rd, 32'd16);
    for (int i = 0; i < 16; i++) begin
      bus(1'b0, 32'h4, 0);
      chk($sformatf("R4 wrapped entry %0d", i), rd, 32'h10 + 32'(i));
    end
    bus(1'b0, 32'h4, 0); chk("R3 empty after drain", rd, 32'hFFFF_FFFF);

    // R6 push and pop in one cycle
    send(8'h77);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 32'h4;
    rx_valid = 1'b1; rx_byte = 8'h88;
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0; rx_valid = 1'b0;
    chk("R6 popped value", rsp_rdata, 32'h77);
    bus(1'b0, 32'h8, 0); chk("R6 occupancy unchanged", rd, 32'd1);
    bus(1'b0, 32'h4, 0); chk("R6 pushed value", rd, 32'h88);

    // R7 transmit
    bus(1'b1, 32'h4, 32'h1234_56AB);
    chk("R7 tx_valid", {31'h0, tv}, 32'd1);
    chk("R7 tx_byte", {24'h0, tb}, 32'hAB);
    tick(); chk("R7 single pulse", {31'h0, tx_valid}, 32'd0);

    // R11 transmit DMA
    bus(1'b1, 32'h14, 32'd7);
    chk("R11 go pulse", {31'h0, go}, 32'd1);
    chk("R11 length", gl, 32'd7);
    chk("R11 tx addr port", dma_tx_addr, 32'h1000);
    bus(1'b1, 32'h14, 32'd0);
    chk("R11 zero count no pulse", {31'h0, go}, 32'd0);

    // R8 unconditional term
    bus(1'b1, 32'hC, 32'h2); tick();
    chk("R8 bit 1 forces irq", {31'h0, irq}, 32'd1);

    // R9 receive DMA with R8 completion term
    bus(1'b1, 32'hC, 32'h4); tick();
    chk("R8 bit 2 with zero remaining", {31'h0, irq}, 32'd1);
    bus(1'b1, 32'h1C, 32'd2); tick();
    chk("R8 irq low while DMA pending", {31'h0, irq}, 32'd0);
    send(8'h5A);
    chk("R9 dma_rx_valid", {31'h0, dv}, 32'd1);
    chk("R9 dma_rx_byte", {24'h0, db}, 32'h5A);
    chk("R9 rx_ready during DMA", {31'h0, rr}, 32'd1);
    chk("R9 remaining after one", dma_rx_remaining, 32'd1);
    send(8'h6B); tick();
    chk("R8 irq after DMA done", {31'h0, irq}, 32'd1);
    bus(1'b0, 32'h1C, 0); chk("R9 remaining zero", rd, 32'd0);
    bus(1'b0, 32'h18, 0); chk("R9 address advanced", rd, 32'h2002);
    bus(1'b0, 32'h8, 0); chk("R9 FIFO untouched", rd, 32'd0);

    // R10 address write cancels
    bus(1'b1, 32'h1C, 32'd5);
    chk("R9 remaining loaded", dma_rx_remaining, 32'd5);
    bus(1'b1, 32'h18, 32'h3000);
    bus(1'b0, 32'h1C, 0); chk("R10 remaining cleared", rd, 32'd0);
    chk("R10 address port", dma_rx_addr, 32'h3000);

    summary();
  end
endmodule